// File: doc/BRIEF.md
# Firmware Image Load Port

This block lets a host place a program image into the program RAM of an embedded CPU and then start that CPU. The host reaches it through a narrow 16-bit register port with a write strobe, a read strobe and a 4-bit register address. The sequence runs as follows. The host puts the 5-bit run-control field into load mode and writes an image start address. It arms the indirect command register and checks that the indirect status reads 0 or 1. It then writes the image one 16-bit word at a time into a single load register. Each accepted word lands in the program RAM at an address that advances by one after every store.

When the image is in place, the host writes a 32-bit reset vector as a low half and then a high half. It then writes the start code into the run-control field. That write copies the vector into the CPU program-counter output and releases the CPU reset output. The CPU reads the RAM through a separate synchronous fetch port.

Top module: `fw_image_loader`

## Requirements
- R1: After reset, `cpu_rst_n` is 0 and `cpu_pc` is 0. The run-control register, the word pointer and the indirect status all read 0.
- R2: The register map is: 0 run control, 1 start address, 2 indirect command, 3 load (write only, reads 0), 4 indirect status, 5 vector low half, 6 vector high half. Read data appears on `reg_rdata` in the cycle after the `reg_rd` cycle. Register 0 keeps only bits 4:0 and reads 0 in bits 15:5. Register 1 reads back the current word pointer. Register 2 reads back all 16 bits as written.
- R3: A load write is accepted only when both of these hold. First, the run-control field equals 0x17. Second, the indirect command register is armed, meaning bits 15:14 are 11 and bits 13:2 are all 0. A load write that is not accepted changes neither the RAM, the pointer nor the status.
- R4: An accepted load write stores its 16-bit word at RAM index (pointer − 0x1000) and raises the pointer by one. Writing the start-address register sets the pointer to the written value. The host packs two image bytes little-endian, with the lower-addressed byte in bits 7:0.
- R5: After an accepted load write the indirect status reads 1. Any write to the start-address register sets the status to 0.
- R6: A load write that would be accepted, but whose pointer lies outside the window 0x1000 to 0x1000+depth−1, is dropped. The RAM and the pointer stay unchanged, and the status reads 8.
- R7: Registers 5 and 6 hold bits 15:0 and bits 31:16 of the 32-bit reset vector.
- R8: Writing a value whose bits 4:0 equal 0x01 to register 0, while the field is not already 0x01, has an effect on the next clock edge. `cpu_pc` takes the reset vector and `cpu_rst_n` goes to 1. Writing the vector or rewriting 0x01 while the CPU runs does not change `cpu_pc`.
- R9: Writing any other field value to register 0 drives `cpu_rst_n` to 0 on the next edge and keeps `cpu_pc`.
- R10: `fetch_data` shows the RAM word at `fetch_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| cpu_rst_n | output | 1 | CPU reset, active low |
| cpu_pc | output | 32 | CPU program counter start value |
| fetch_addr | input | 8 | CPU fetch word index |
| fetch_data | output | 16 | CPU fetch word |

## Verification
The hardest case to reach from the ports is the window edge. A word must be stored at the last RAM index, and the very next word must then be refused with the status showing the fault while the pointer stays put. The stimulus reaches it by loading the start address with one less than the window end, storing one word and storing a second. It then reads back the status and the pointer and fetches both the last index and index 0. The index-0 fetch shows that nothing wrapped. A pointer below the window is also loaded to show that the fault covers that side too.

// File: rtl/fwl_pkg.sv
`timescale 1ns/1ps
package fwl_pkg;
  localparam int CTRL_W = 5;
  localparam logic [CTRL_W-1:0] RUN_LOAD = 5'h17;
  localparam logic [CTRL_W-1:0] RUN_GO   = 5'h01;

  localparam int A_RUN   = 0;
  localparam int A_BASE  = 1;
  localparam int A_XCMD  = 2;
  localparam int A_XLOAD = 3;
  localparam int A_XSTAT = 4;
  localparam int A_VLO   = 5;
  localparam int A_VHI   = 6;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'h0,
    ST_DONE  = 4'h1,
    ST_FAULT = 4'h8
  } ld_status_e;
endpackage

// File: rtl/fwl_regs.sv
`timescale 1ns/1ps
module fwl_regs
  import fwl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int REG_AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic [WORD_W-1:0]   ptr,
  input  logic [WORD_W-1:0]   status,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                load_en,
  output logic                base_wr,
  output logic                load_wr,
  output logic                go_pulse,
  output logic                halt_pulse,
  output logic [2*WORD_W-1:0] vector
);
  localparam int VEC_HALVES = 2;

  logic [CTRL_W-1:0] run_q, run_d;
  logic [WORD_W-1:0] xcmd_q, xcmd_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              run_wr, armed;

  assign run_wr     = reg_wr && (reg_addr == REG_AW'(A_RUN));
  assign base_wr    = reg_wr && (reg_addr == REG_AW'(A_BASE));
  assign load_wr    = reg_wr && (reg_addr == REG_AW'(A_XLOAD));
  assign go_pulse   = run_wr && (reg_wdata[CTRL_W-1:0] == RUN_GO) && (run_q != RUN_GO);
  assign halt_pulse = run_wr && (reg_wdata[CTRL_W-1:0] != RUN_GO);

  assign armed   = (xcmd_q[WORD_W-1 -: 2] == 2'b11) && (xcmd_q[WORD_W-3:2] == '0);
  assign load_en = armed && (run_q == RUN_LOAD);

  always_comb begin
    run_d  = run_q;
    xcmd_d = xcmd_q;
    if (run_wr) run_d = reg_wdata[CTRL_W-1:0];
    if (reg_wr && (reg_addr == REG_AW'(A_XCMD))) xcmd_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      xcmd_q <= '0;
    end else begin
      run_q  <= run_d;
      xcmd_q <= xcmd_d;
    end
  end

  for (genvar h = 0; h < VEC_HALVES; h++) begin : g_half
    logic [WORD_W-1:0] half_q, half_d;
    always_comb begin
      half_d = half_q;
      if (reg_wr && (reg_addr == REG_AW'(A_VLO + h))) half_d = reg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= '0;
      else        half_q <= half_d;
    end
    assign vector[h*WORD_W +: WORD_W] = half_q;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) begin
      case (reg_addr)
        REG_AW'(A_RUN):   rdata_d = WORD_W'(run_q);
        REG_AW'(A_BASE):  rdata_d = ptr;
        REG_AW'(A_XCMD):  rdata_d = xcmd_q;
        REG_AW'(A_XSTAT): rdata_d = status;
        REG_AW'(A_VLO):   rdata_d = vector[WORD_W-1:0];
        REG_AW'(A_VHI):   rdata_d = vector[2*WORD_W-1:WORD_W];
        default:          rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/fwl_addr_gen.sv
`timescale 1ns/1ps
module fwl_addr_gen
  import fwl_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int RAM_DEPTH = 256,
  parameter int WIN_BASE  = 32'h1000,
  localparam int IDX_W    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic              load_wr,
  input  logic              load_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ptr,
  output logic [WORD_W-1:0] status,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [WORD_W-1:0] ram_wdata
);
  localparam logic [WORD_W-1:0] WIN_L   = WORD_W'(WIN_BASE);
  localparam logic [WORD_W:0]   DEPTH_L = (WORD_W+1)'(RAM_DEPTH);

  logic [WORD_W-1:0] ptr_q, ptr_d, offset;
  ld_status_e        st_q, st_d;
  logic              we_q, we_d, in_win;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] dat_q, dat_d;

  assign offset = ptr_q - WIN_L;
  assign in_win = (ptr_q >= WIN_L) && ({1'b0, offset} < DEPTH_L);

  always_comb begin
    ptr_d = ptr_q;
    st_d  = st_q;
    we_d  = 1'b0;
    idx_d = idx_q;
    dat_d = dat_q;
    if (base_wr) begin
      ptr_d = wdata;
      st_d  = ST_IDLE;
    end else if (load_wr && load_en) begin
      if (in_win) begin
        we_d  = 1'b1;
        idx_d = offset[IDX_W-1:0];
        dat_d = wdata;
        ptr_d = ptr_q + 1'b1;
        st_d  = ST_DONE;
      end else begin
        st_d  = ST_FAULT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      st_q  <= ST_IDLE;
      we_q  <= 1'b0;
      idx_q <= '0;
      dat_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      st_q  <= st_d;
      we_q  <= we_d;
      idx_q <= idx_d;
      dat_q <= dat_d;
    end
  end

  assign ptr       = ptr_q;
  assign status    = WORD_W'(st_q);
  assign ram_we    = we_q;
  assign ram_idx   = idx_q;
  assign ram_wdata = dat_q;
endmodule

// File: rtl/fwl_run_ctl.sv
`timescale 1ns/1ps
module fwl_run_ctl #(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_pulse,
  input  logic                halt_pulse,
  input  logic [2*WORD_W-1:0] vector,
  output logic                cpu_rst_n,
  output logic [2*WORD_W-1:0] cpu_pc
);
  logic                run_q, run_d;
  logic [2*WORD_W-1:0] pc_q, pc_d;

  always_comb begin
    run_d = run_q;
    pc_d  = pc_q;
    if (go_pulse) begin
      run_d = 1'b1;
      pc_d  = vector;
    end else if (halt_pulse) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      run_q <= run_d;
      pc_q  <= pc_d;
    end
  end

  assign cpu_rst_n = run_q;
  assign cpu_pc    = pc_q;
endmodule

// File: rtl/fwl_pram.sv
`timescale 1ns/1ps
module fwl_pram #(
  parameter int WORD_W    = 16,
  parameter int RAM_DEPTH = 256,
  localparam int IDX_W    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [RAM_DEPTH];
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[ridx];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/fw_image_loader.sv
`timescale 1ns/1ps
module fw_image_loader #(
  parameter int WORD_W    = 16,
  parameter int REG_AW    = 4,
  parameter int RAM_DEPTH = 256,
  parameter int WIN_BASE  = 32'h1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic [WORD_W-1:0]            reg_wdata,
  output logic [WORD_W-1:0]            reg_rdata,
  output logic                         cpu_rst_n,
  output logic [2*WORD_W-1:0]          cpu_pc,
  input  logic [$clog2(RAM_DEPTH)-1:0] fetch_addr,
  output logic [WORD_W-1:0]            fetch_data
);
  localparam int IDX_W = $clog2(RAM_DEPTH);

  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic [WORD_W-1:0]   ptr, status, ram_wdata;
  logic                load_en, base_wr, load_wr, go_pulse, halt_pulse, ram_we;
  logic [2*WORD_W-1:0] vector;
  logic [IDX_W-1:0]    ram_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fwl_regs #(.WORD_W(WORD_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ptr(ptr), .status(status),
    .reg_rdata(reg_rdata), .load_en(load_en), .base_wr(base_wr),
    .load_wr(load_wr), .go_pulse(go_pulse), .halt_pulse(halt_pulse),
    .vector(vector)
  );

  fwl_addr_gen #(.WORD_W(WORD_W), .RAM_DEPTH(RAM_DEPTH), .WIN_BASE(WIN_BASE)) u_agen (
    .clk(clk), .rst_n(rst_sync_n), .base_wr(base_wr), .load_wr(load_wr),
    .load_en(load_en), .wdata(reg_wdata), .ptr(ptr), .status(status),
    .ram_we(ram_we), .ram_idx(ram_idx), .ram_wdata(ram_wdata)
  );

  fwl_run_ctl #(.WORD_W(WORD_W)) u_run (
    .clk(clk), .rst_n(rst_sync_n), .go_pulse(go_pulse),
    .halt_pulse(halt_pulse), .vector(vector),
    .cpu_rst_n(cpu_rst_n), .cpu_pc(cpu_pc)
  );

  fwl_pram #(.WORD_W(WORD_W), .RAM_DEPTH(RAM_DEPTH)) u_pram (
    .clk(clk), .we(ram_we), .widx(ram_idx), .wdata(ram_wdata),
    .ridx(fetch_addr), .rdata(fetch_data)
  );
endmodule

// File: rtl/fwl_chk.sv
`timescale 1ns/1ps
module fwl_chk
  import fwl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int REG_AW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [REG_AW-1:0]   reg_addr,
  input logic                load_en,
  input logic                go_pulse,
  input logic                halt_pulse,
  input logic                ram_we,
  input logic [WORD_W-1:0]   ptr,
  input logic [WORD_W-1:0]   status,
  input logic [2*WORD_W-1:0] vector,
  input logic                cpu_rst_n,
  input logic [2*WORD_W-1:0] cpu_pc
);
  // R3: a refused load write leaves RAM and pointer alone
  p_refused_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_AW'(A_XLOAD) && !load_en) |=> (!ram_we && $stable(ptr)));

  // R4: every RAM store comes with a pointer step of one
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ptr == WORD_W'($past(ptr) + 1'b1)));

  // R6: entering the fault status never stores and never moves the pointer
  p_fault_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == WORD_W'(ST_FAULT) && $past(status) != WORD_W'(ST_FAULT)) |-> (!ram_we && $stable(ptr)));

  // R8: start copies the vector and releases the CPU
  p_go_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |=> (cpu_rst_n && cpu_pc == $past(vector)));

  // R8: the CPU stays in reset until a start
  p_hold_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rst_n && !go_pulse) |=> !cpu_rst_n);

  // R9: leaving start mode resets the CPU and keeps the program counter
  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |=> (!cpu_rst_n && $stable(cpu_pc)));
endmodule

bind fw_image_loader fwl_chk #(.WORD_W(WORD_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .load_en(load_en), .go_pulse(go_pulse), .halt_pulse(halt_pulse),
  .ram_we(ram_we), .ptr(ptr), .status(status), .vector(vector),
  .cpu_rst_n(cpu_rst_n), .cpu_pc(cpu_pc)
);

// File: tb/tb_fw_image_loader.sv
`timescale 1ns/1ps
module tb_fw_image_loader;
  localparam int A_RUN = 0, A_BASE = 1, A_XCMD = 2, A_XLOAD = 3;
  localparam int A_XSTAT = 4, A_VLO = 5, A_VHI = 6;

  logic        clk, rst_n, reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, fetch_data;
  logic        cpu_rst_n;
  logic [31:0] cpu_pc;
  logic [7:0]  fetch_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] fexp_q[$];
  string       ftag_q[$];
  logic        rd_pend, fe_go, fe_pend;

  fw_image_loader dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_rst_n(cpu_rst_n), .cpu_pc(cpu_pc),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    rd_pend <= reg_rd;
    fe_pend <= fe_go;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rd_pend === 1'b1 && exp_q.size() > 0)
      chk(tag_q.pop_front(), {16'h0, reg_rdata}, {16'h0, exp_q.pop_front()});
    if (fe_pend === 1'b1 && fexp_q.size() > 0)
      chk(ftag_q.pop_front(), {16'h0, fetch_data}, {16'h0, fexp_q.pop_front()});
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [15:0] e, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic fetch(input int i, input logic [15:0] e, input string tag);
    @(negedge clk);
    fetch_addr = 8'(i); fe_go = 1'b1;
    fexp_q.push_back(e); ftag_q.push_back(tag);
    @(negedge clk);
    fe_go = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; fetch_addr = '0; fe_go = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cpu_rst_n in reset", {31'h0, cpu_rst_n}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cpu_rst_n", {31'h0, cpu_rst_n}, 32'h0);
    chk("R1 cpu_pc", cpu_pc, 32'h0);
    rd(A_RUN, 16'h0000, "R1 run reg");
    rd(A_XSTAT, 16'h0000, "R1 status");
    rd(A_BASE, 16'h0000, "R1 pointer");

    // R3: not armed
    wr(A_RUN, 16'h0017);
    wr(A_BASE, 16'h1000);
    wr(A_XLOAD, 16'hAAAA);
    rd(A_BASE, 16'h1000, "R3 unarmed pointer");
    rd(A_XSTAT, 16'h0000, "R3 unarmed status");
    wr(A_XCMD, 16'hC020);
    wr(A_XLOAD, 16'hBBBB);
    rd(A_BASE, 16'h1000, "R3 bit5 set pointer");
    rd(A_XCMD, 16'hC020, "R2 command readback");

    // R4/R5: stream four words
    wr(A_XCMD, 16'hC003);
    wr(A_XLOAD, 16'h3412);
    wr(A_XLOAD, 16'h7856);
    wr(A_XLOAD, 16'hBC9A);
    wr(A_XLOAD, 16'hF0DE);
    rd(A_BASE, 16'h1004, "R4 pointer after four");
    rd(A_XSTAT, 16'h0001, "R5 status done");
    @(negedge clk);
    fetch(0, 16'h3412, "R10 word0");
    fetch(1, 16'h7856, "R4 word1");
    fetch(2, 16'hBC9A, "R4 word2");
    fetch(3, 16'hF0DE, "R4 word3");

    // R3: not in load mode
    wr(A_RUN, 16'h0000);
    wr(A_XLOAD, 16'h5555);
    rd(A_BASE, 16'h1004, "R3 idle mode pointer");
    rd(A_XSTAT, 16'h0001, "R3 idle mode status");
    wr(A_RUN, 16'h0017);
    wr(A_XLOAD, 16'h6666);
    rd(A_BASE, 16'h1005, "R4 pointer resumes");
    @(negedge clk);
    fetch(4, 16'h6666, "R4 word4");
    fetch(3, 16'hF0DE, "R3 word3 untouched");

    // R5: base write clears status, overwrite index 0
    wr(A_BASE, 16'h1000);
    rd(A_XSTAT, 16'h0000, "R5 status cleared");
    wr(A_XLOAD, 16'h1111);
    @(negedge clk);
    fetch(0, 16'h1111, "R4 overwrite word0");

    // R6: window end
    wr(A_BASE, 16'h10FF);
    wr(A_XLOAD, 16'h2222);
    rd(A_BASE, 16'h1100, "R6 last index pointer");
    rd(A_XSTAT, 16'h0001, "R6 last index status");
    wr(A_XLOAD, 16'h3333);
    rd(A_XSTAT, 16'h0008, "R6 fault status");
    rd(A_BASE, 16'h1100, "R6 fault pointer held");
    @(negedge clk);
    fetch(255, 16'h2222, "R6 last word kept");
    fetch(0, 16'h1111, "R6 no wrap");
    wr(A_BASE, 16'h0FFF);
    wr(A_XLOAD, 16'h4444);
    rd(A_XSTAT, 16'h0008, "R6 below window");
    rd(A_BASE, 16'h0FFF, "R6 below pointer held");

    // R2: field width
    wr(A_RUN, 16'hFFF7);
    rd(A_RUN, 16'h0017, "R2 run field only");

    // R7/R8/R9
    wr(A_VLO, 16'h2000);
    wr(A_VHI, 16'h0000);
    rd(A_VLO, 16'h2000, "R7 vector low");
    rd(A_VHI, 16'h0000, "R7 vector high");
    chk("R8 held before start", {31'h0, cpu_rst_n}, 32'h0);
    wr(A_RUN, 16'h0001);
    chk("R8 released", {31'h0, cpu_rst_n}, 32'h1);
    chk("R8 pc", cpu_pc, 32'h0000_2000);
    wr(A_VLO, 16'h1234);
    wr(A_RUN, 16'h0001);
    chk("R8 pc kept while running", cpu_pc, 32'h0000_2000);
    wr(A_RUN, 16'h0000);
    chk("R9 reset asserted", {31'h0, cpu_rst_n}, 32'h0);
    chk("R9 pc kept", cpu_pc, 32'h0000_2000);
    wr(A_VHI, 16'h0001);
    wr(A_RUN, 16'h0021);
    chk("R8 second start", {31'h0, cpu_rst_n}, 32'h1);
    chk("R8 second pc", cpu_pc, 32'h0001_1234);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule